// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Oscillator

This block supplies the switching-period timing for a fixed-frequency PWM power stage. It counts system clocks to mark the start of each switching period and opens a gate window whose length follows a duty request code. The gate window is never longer than three quarters of the period. The period is not held constant. It is stepped once per switching period along a triangle that spans about ±4 % of the nominal value and repeats every 4 ms. This spreads the switching energy over a band of frequencies.

Each gate window begins with a leading-edge blanking interval. An external current-sense comparator can end the on-time early through a terminate input, but the block ignores that input during blanking. Dropping the enable forces the gate low at once and restarts the modulation from its shortest period. The nominal frequency (65, 100 or 130 kHz in practice), the clock rate, the deviation and the modulation length are parameters. All internal values are clock counts.

Top module: `pwm_jitter_osc`

## Requirements
- R1: While reset is asserted, and while `en_i` is low, `start_o`, `gate_o` and `blank_o` are 0 and `per_o` equals the shortest period P_MIN.
- R2: With `en_i` high, `start_o` is high for exactly one clock at the beginning of every period, including the first clock after enable rises, and each period lasts `per_o` clocks.
- R3: The k-th period after enable (k counted from 0, m = k mod 2·N_HALF) is P_MIN + floor(m·SPAN/N_HALF) for m < N_HALF, and P_MAX − floor((m−N_HALF)·SPAN/N_HALF) otherwise.
- R4: The period values are derived as follows:
  - P_NOM = CLK_HZ/FSW_HZ
  - DEV = floor(P_NOM·DEV_PCT/100)
  - P_MIN = P_NOM − DEV and P_MAX = P_NOM + DEV
  - SPAN = 2·DEV
  - N_HALF = MOD_US·FSW_HZ/2 000 000, which is half the switching periods in one modulation cycle.
- R5: The gate is high from the first clock of a period for ON = min(floor(duty·P/2^DUTY_W), floor(3·P/4)) clocks, where P is that period's length. Duty 0 gives no gate pulse.
- R6: The duty code is sampled on the last clock of each period, and continuously while disabled. A change made during a period takes effect in the next period.
- R7: `blank_o` is high during the first LEB_CLKS clocks of the gate window, and only while `gate_o` is high. `term_i` has no effect during blanking.
- R8: `term_i` sampled high while the gate is high after blanking drops `gate_o` from the next clock until the period ends. `term_i` on the last clock of a period, or while the gate is low, has no effect on any period.
- R9: When `en_i` falls, `gate_o`, `blank_o` and `start_o` go low in the same cycle. The modulation phase is reset, so the next enable starts with a period of P_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| duty_i | input | DUTY_W | Duty request code, fraction of 2^DUTY_W |
| term_i | input | 1 | Terminate current on-time (from current comparator) |
| start_o | output | 1 | One-clock pulse at each period start |
| gate_o | output | 1 | Gate-on window after capping and termination |
| blank_o | output | 1 | Leading-edge blanking window |
| per_o | output | PER_W | Length of the current period in clocks |

## Verification
Two events can land on the same clock: a terminate request and the clock that closes blanking or the period. The bench places `term_i` on the last blanked clock, on the first clock after blanking, and on the last clock of a period. It expects, in turn, no effect, a cut on the next clock, and an untouched following period. Duty changes are made while a period is running, at the same time that the triangle steps the period at the period boundary. Each gate window is judged against the ON formula using the period the bench has computed independently for that cycle.

// File: rtl/jit_pkg.sv
`timescale 1ns/100ps
package jit_pkg;

  // Period length for a triangle phase step: rising or falling half.
  function automatic int per_of(input bit rising, input int ph,
                                input int pmin, input int span, input int nhalf);
    int step;
    step = (ph * span) / nhalf;
    return rising ? (pmin + step) : (pmin + span - step);
  endfunction

  // On-time in clocks: linear duty share, clipped to three quarters.
  function automatic int on_clocks(input int duty, input int per, input int dw);
    int lin;
    int cap;
    lin = (duty * per) >> dw;
    cap = (3 * per) >> 2;
    return (lin < cap) ? lin : cap;
  endfunction

endpackage

// File: rtl/jit_tri_gen.sv
`timescale 1ns/100ps
module jit_tri_gen #(
  parameter int P_MIN  = 480,
  parameter int SPAN   = 40,
  parameter int N_HALF = 200,
  parameter int PER_W  = 10,
  localparam int PH_W  = (N_HALF > 1) ? $clog2(N_HALF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             adv_i,
  output logic [PER_W-1:0] per_o
);
  logic [PH_W-1:0] ph_q;
  logic            rise_q;
  logic            turn;

  assign turn = (ph_q == PH_W'(N_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      rise_q <= 1'b1;
    end else if (!en_i) begin
      ph_q   <= '0;
      rise_q <= 1'b1;
    end else if (adv_i) begin
      if (turn) begin
        ph_q   <= '0;
        rise_q <= !rise_q;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign per_o = PER_W'(jit_pkg::per_of(rise_q, int'(ph_q), P_MIN, SPAN, N_HALF));

  // R3
  rise_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i) && $past(adv_i) && rise_q && $past(rise_q) |-> per_o >= $past(per_o));
  // R3
  fall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i) && $past(adv_i) && !rise_q && !$past(rise_q) |-> per_o <= $past(per_o));
endmodule

// File: rtl/jit_cycle_ctr.sv
`timescale 1ns/100ps
module jit_cycle_ctr #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] per_i,
  output logic [PER_W-1:0] cnt_o,
  output logic             start_o,
  output logic             wrap_o
);
  logic [PER_W-1:0] cnt_q;

  assign wrap_o  = en_i && (cnt_q == per_i - 1'b1);
  assign start_o = en_i && (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_q < per_i);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i) && !$past(wrap_o) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/jit_gate_win.sv
`timescale 1ns/100ps
module jit_gate_win #(
  parameter int PER_W    = 10,
  parameter int DUTY_W   = 8,
  parameter int LEB_CLKS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wrap_i,
  input  logic [PER_W-1:0]  cnt_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              term_i,
  output logic              gate_o,
  output logic              blank_o
);
  logic [DUTY_W-1:0] duty_q;
  logic [PER_W-1:0]  on_len;
  logic              cut_q;
  logic              in_blank;
  logic              cut_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                duty_q <= '0;
    else if (!en_i || wrap_i)  duty_q <= duty_i;
  end

  assign on_len   = PER_W'(jit_pkg::on_clocks(int'(duty_q), int'(per_i), DUTY_W));
  assign in_blank = int'(cnt_i) < LEB_CLKS;
  assign gate_o   = en_i && (cnt_i < on_len) && !cut_q;
  assign blank_o  = gate_o && in_blank;
  assign cut_hit  = term_i && gate_o && !in_blank && !wrap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cut_q <= 1'b0;
    else if (!en_i || wrap_i)  cut_q <= 1'b0;
    else if (cut_hit)          cut_q <= 1'b1;
  end

  // R5
  duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (4 * int'(cnt_i)) < (3 * int'(per_i)));
  // R9
  off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !gate_o && !blank_o);
  // R7
  blank_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> gate_o);
  // R8
  term_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i && term_i && gate_o && !blank_o && !wrap_i) |-> !gate_o);
endmodule

// File: rtl/pwm_jitter_osc.sv
`timescale 1ns/100ps
module pwm_jitter_osc #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int FSW_HZ   = 100_000,
  parameter int DEV_PCT  = 4,
  parameter int MOD_US   = 4000,
  parameter int DUTY_W   = 8,
  parameter int LEB_CLKS = 13,
  localparam int P_NOM   = CLK_HZ / FSW_HZ,
  localparam int P_DEV   = (P_NOM * DEV_PCT) / 100,
  localparam int P_MIN   = P_NOM - P_DEV,
  localparam int SPAN    = 2 * P_DEV,
  localparam int P_MAX   = P_MIN + SPAN,
  localparam int N_HALF  = (MOD_US * FSW_HZ) / 2_000_000,
  localparam int PER_W   = $clog2(P_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              term_i,
  output logic              start_o,
  output logic              gate_o,
  output logic              blank_o,
  output logic [PER_W-1:0]  per_o
);
  logic [PER_W-1:0] cnt;
  logic             wrap;

  jit_tri_gen #(.P_MIN(P_MIN), .SPAN(SPAN), .N_HALF(N_HALF), .PER_W(PER_W)) u_tri (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .adv_i(wrap), .per_o(per_o)
  );

  jit_cycle_ctr #(.PER_W(PER_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .per_i(per_o),
    .cnt_o(cnt), .start_o(start_o), .wrap_o(wrap)
  );

  jit_gate_win #(.PER_W(PER_W), .DUTY_W(DUTY_W), .LEB_CLKS(LEB_CLKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wrap_i(wrap), .cnt_i(cnt),
    .per_i(per_o), .duty_i(duty_i), .term_i(term_i),
    .gate_o(gate_o), .blank_o(blank_o)
  );

  // R4
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_o >= PER_W'(P_MIN) && per_o <= PER_W'(P_MAX));
  // R2
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i) && !start_o |-> $stable(per_o));
  // R1
  idle_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_i) |-> per_o == PER_W'(P_MIN));
endmodule

// File: tb/tb_pwm_jitter_osc.sv
`timescale 1ns/100ps
module tb_pwm_jitter_osc;
  localparam int CLK_HZ = 10_000_000;
  localparam int FSW_HZ = 100_000;
  localparam int DEV_PCT = 4;
  localparam int MOD_US = 4000;
  localparam int DUTY_W = 8;
  localparam int LEB = 3;
  localparam int E_NOM = CLK_HZ / FSW_HZ;
  localparam int E_DEV = E_NOM * DEV_PCT / 100;
  localparam int E_CYC = MOD_US * (FSW_HZ / 1000) / 1000;
  localparam int E_HALF = E_CYC / 2;
  localparam int E_PMIN = E_NOM - E_DEV;
  localparam int PW = $clog2(E_NOM + E_DEV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic [DUTY_W-1:0] duty_i = '0;
  logic term_i = 1'b0;
  logic start_o, gate_o, blank_o;
  logic [PW-1:0] per_o;

  int n_run = 0;
  int n_fail = 0;
  int cur_duty = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_jitter_osc #(.CLK_HZ(CLK_HZ), .FSW_HZ(FSW_HZ), .DEV_PCT(DEV_PCT), .MOD_US(MOD_US),
                   .DUTY_W(DUTY_W), .LEB_CLKS(LEB)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .duty_i(duty_i), .term_i(term_i),
    .start_o(start_o), .gate_o(gate_o), .blank_o(blank_o), .per_o(per_o)
  );

  function automatic int exp_per(input int k);
    int m;
    m = k % E_CYC;
    if (m < E_HALF) return E_PMIN + (m * 2 * E_DEV) / E_HALF;
    return E_NOM + E_DEV - ((m - E_HALF) * 2 * E_DEV) / E_HALF;
  endfunction

  function automatic int exp_on(input int d, input int p);
    int lin;
    lin = d * p / 256;
    return (lin < p * 3 / 4) ? lin : p * 3 / 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tm: 0 none, 1 last blank clock, 2 first clock after blank,
  //     3 last clock of period, 4 after gate ends, 5 inside gate after blank
  task automatic run_cycle(input int k, input int d_next, input int tm, input bit en_now);
    int p, on, ta, eg, eb, es;
    bit te;
    int bs, bg, bb, bp;
    int as_, ag, ab, ap, xs, xg, xb;
    p = exp_per(k);
    on = exp_on(cur_duty, p);
    case (tm)
      1: ta = LEB - 1;
      2: ta = LEB;
      3: ta = p - 1;
      4: ta = (on + 1 < p) ? on + 1 : -1;
      5: ta = LEB + 1;
      default: ta = -1;
    endcase
    te = (ta >= LEB) && (ta < on);
    bs = 0; bg = 0; bb = 0; bp = 0;
    as_ = 0; ag = 0; ab = 0; ap = 0; xs = 0; xg = 0; xb = 0;
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      if (en_now && c == 0) en_i = 1'b1;
      term_i = (c == ta);
      if (c == 1) duty_i = DUTY_W'(d_next);
      #0.5;
      es = (c == 0);
      eg = (c < on) && !(te && c > ta);
      eb = eg && (c < LEB);
      if (int'(start_o) != es && !bs) begin bs = 1; as_ = c; xs = es; end
      if (int'(gate_o) != eg && !bg) begin bg = 1; ag = c; xg = eg; end
      if (int'(blank_o) != eb && !bb) begin bb = 1; ab = c; xb = eb; end
      if (int'(per_o) != p && !bp) begin bp = 1; ap = int'(per_o); end
    end
    chk(!bp, $sformatf("R3 R4 period k=%0d", k), ap, p);
    chk(!bs, $sformatf("R2 start k=%0d at clk %0d", k, as_), !xs, xs);
    chk(!bg, $sformatf("R5 R6 R8 gate k=%0d at clk %0d", k, ag), !xg, xg);
    chk(!bb, $sformatf("R7 blank k=%0d at clk %0d", k, ab), !xb, xb);
    cur_duty = d_next;
  endtask

  initial begin
    #700000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int dn;
    duty_i = 8'd200;
    repeat (3) @(negedge clk);
    #0.5;
    // R1 in reset
    chk(!start_o && !gate_o && !blank_o, "R1 outputs in reset", int'(gate_o), 0);
    chk(int'(per_o) == E_PMIN, "R1 period in reset", int'(per_o), E_PMIN);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    // R1 disabled after reset
    chk(!start_o && !gate_o && !blank_o, "R1 outputs while disabled", int'(gate_o), 0);
    cur_duty = 200;
    // Full modulation cycle plus a few: duty sweep with terminate placement
    for (int k = 0; k < E_CYC + 5; k++) begin
      if (k % 7 == 0) dn = 255;
      else if (k % 11 == 0) dn = 0;
      else dn = (k * 53 + 17) % 256;
      run_cycle(k, dn, k % 6, k == 0);
    end
    // R2 next period starts as expected
    @(negedge clk);
    #0.5;
    chk(start_o == 1'b1, "R2 start after last checked period", int'(start_o), 1);
    chk(int'(gate_o) == int'(exp_on(cur_duty, exp_per(E_CYC + 5)) > 0),
        "R5 gate at period start", int'(gate_o), 1);
    // R9 disable mid-period drops outputs at once
    @(negedge clk);
    en_i = 1'b0;
    #0.5;
    chk(!gate_o && !start_o && !blank_o, "R9 outputs drop with enable", int'(gate_o), 0);
    @(negedge clk);
    term_i = 1'b1;
    duty_i = 8'd255;
    repeat (4) @(negedge clk);
    term_i = 1'b0;
    #0.5;
    chk(int'(per_o) == E_PMIN, "R9 phase reset while disabled", int'(per_o), E_PMIN);
    chk(!gate_o, "R9 gate low while disabled with term", int'(gate_o), 0);
    cur_duty = 255;
    // R9 restart at P_MIN, R5 cap at full duty, R8 cut inside gate
    run_cycle(0, 64, 5, 1'b1);
    run_cycle(1, 64, 0, 1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule